// File: doc/BRIEF.md
# IF frequency window counter

This block decides whether an intermediate-frequency signal sits close enough to its expected value for a radio search routine to stop on a station. It counts IF edges over a gate time taken from a crystal-derived tick, and compares the count against a target that the mode, the centre code and the gate length set together. A preloaded down-counter does the comparison. It is loaded with the expected count, and each IF edge in the gate takes one away. At the end of the gate, whatever is left in the counter is read as a signed difference. The result is true when that difference lies within a tolerance that scales with the window code and with the gate length.

The configuration fields come from a register bank outside this block. The bank pulses `cfg_wr` whenever it changes a field, and the fields change only in that cycle. The IF inputs arrive as single-clock edge pulses that have already been synchronised. Each finished gate gives a one-clock `result_valid` strobe. `stop_out` takes the new verdict in the same cycle and holds it until the next gate ends.

Top module: `if_window_counter`

## Requirements
- R1: One time-base period is (`cfg_ref_div` + 1) cycles in which `osc_tick` is high. Cycles in which `osc_tick` is low do not advance the timer.
- R2: `cfg_mode` encoding: 01 selects FM mode and counts `if_fm_pulse`. 10 selects AM mode and 11 selects AM upconversion mode, and both count `if_am_pulse`. Pulses on the input that is not selected have no effect on the result.
- R3: A gate lasts 2^(7 − `cfg_samp`) time-base periods. `cfg_wr` is sampled at clock edge E0 and the osc tick is high every cycle. The first `result_valid` is then high after edge E(gate periods × (`cfg_ref_div` + 1)).
- R4: The expected count P is (B + `cfg_ctr`) × 2^(7 − `cfg_samp`). B is 1696 in FM mode, 448 in AM mode and 10688 in upconversion mode.
- R5: For `cfg_win` from 3 to 7, the tolerance W is 2^(`cfg_win` − 3) × 2^(7 − `cfg_samp`) counts. N is the number of pulses counted in the gate. The verdict is 1 exactly when |P − N| ≤ W, with both limits included.
- R6: `result_valid` is high for one clock at each gate end, and `stop_out` updates with it. Between gate ends `stop_out` keeps its value.
- R7: The block is idle when `cfg_mode` = 00, when `cfg_enable` = 0, or when `cfg_win` is 0, 1 or 2. While idle, `stop_out` is 0 from the next clock on and `result_valid` never rises.
- R8: `cfg_wr` discards the gate in progress. `result_valid` is low in the cycle after the write, and a full new gate starts from a fresh preload.
- R9: After reset, `result_valid` and `stop_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per crystal oscillator period |
| if_am_pulse | input | 1 | Synchronised AM IF edge pulse |
| if_fm_pulse | input | 1 | Synchronised FM IF edge pulse |
| cfg_wr | input | 1 | Pulses in the cycle any field changes |
| cfg_mode | input | 2 | Measurement mode (00 idle, 01 FM, 10 AM, 11 AM upconversion) |
| cfg_enable | input | 1 | 0 holds the counter in standby |
| cfg_ref_div | input | 14 | Time-base divider minus one |
| cfg_samp | input | 3 | Gate length code |
| cfg_win | input | 3 | Tolerance code (0 to 2 reserved) |
| cfg_ctr | input | 5 | Centre frequency code |
| result_valid | output | 1 | One-clock strobe at gate end |
| stop_out | output | 1 | Held in-window verdict |

## Verification
The hardest cases to reach are the two edges of the window, where the residual is exactly +W or −W and one more pulse flips the verdict. The bench can only get there if it knows precisely which clock edges fall inside the gate. It therefore starts every measurement with a configuration write, which fixes the gate origin. It then places all N pulses in the first N cycles after that write, well inside the gate, so the count is exact. The same timing makes it possible to interrupt a gate part way through with a second write and to show that the earlier pulses were dropped.

// File: rtl/ifw_pkg.sv
package ifw_pkg;
  typedef enum logic [1:0] {
    IFM_OFF = 2'b00,
    IFM_FM  = 2'b01,
    IFM_AM  = 2'b10,
    IFM_UPC = 2'b11
  } ifw_mode_e;

  localparam int MODE_W = 2;
  localparam int SAMP_W = 3;
  localparam int WIN_W  = 3;
  localparam int CTR_W  = 5;
endpackage

// File: rtl/ifw_timebase.sv
module ifw_timebase #(
  parameter int REF_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             osc_tick,
  input  logic [REF_W-1:0] ref_div,
  output logic             base_tick
);
  logic [REF_W-1:0] pres_q;
  logic             wrap;

  assign wrap      = (pres_q >= ref_div);
  assign base_tick = !restart && osc_tick && wrap;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pres_q <= '0;
    end else if (osc_tick) begin
      pres_q <= wrap ? '0 : pres_q + 1'b1;
    end
  end

  // the divider never runs past its limit while a gate is live
  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (pres_q <= ref_div)); // R1
endmodule

// File: rtl/ifw_gate.sv
module ifw_gate #(
  parameter int SHIFT_W = 3,
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1,
  localparam int GATE_W = MAX_SHIFT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               base_tick,
  input  logic [SHIFT_W-1:0] samp,
  output logic               gate_end
);
  logic [SHIFT_W-1:0] sh;
  logic [GATE_W-1:0]  last;
  logic [GATE_W-1:0]  gcnt_q;

  assign sh       = SHIFT_W'(MAX_SHIFT) - samp;
  assign last     = (GATE_W'(1) << sh) - GATE_W'(1);
  assign gate_end = base_tick && (gcnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      gcnt_q <= '0;
    end else if (base_tick) begin
      gcnt_q <= (gcnt_q >= last) ? '0 : gcnt_q + 1'b1;
    end
  end

  AST_GATE_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (gcnt_q <= last)); // R3
endmodule

// File: rtl/ifw_target.sv
module ifw_target #(
  parameter int CNT_W    = 21,
  parameter int SHIFT_W  = 3,
  parameter int WIN_W    = 3,
  parameter int CTR_W    = 5,
  parameter int FM_BASE  = 1696,
  parameter int AM_BASE  = 448,
  parameter int UPC_BASE = 10688,
  parameter int WIN_MIN  = 3,
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1
) (
  input  logic [1:0]         mode,
  input  logic [SHIFT_W-1:0] samp,
  input  logic [WIN_W-1:0]   win,
  input  logic [CTR_W-1:0]   ctr,
  output logic [CNT_W-1:0]   preload,
  output logic [CNT_W-1:0]   win_cnt
);
  import ifw_pkg::*;

  logic [SHIFT_W-1:0] sh;
  logic [CNT_W-1:0]   base_v;
  logic [CNT_W-1:0]   centre;

  assign sh = SHIFT_W'(MAX_SHIFT) - samp;

  always_comb begin
    unique case (ifw_mode_e'(mode))
      IFM_FM:  base_v = CNT_W'(FM_BASE);
      IFM_AM:  base_v = CNT_W'(AM_BASE);
      IFM_UPC: base_v = CNT_W'(UPC_BASE);
      default: base_v = '0;
    endcase
  end

  assign centre  = base_v + CNT_W'(ctr);
  assign preload = centre << sh;

  always_comb begin
    if (int'(win) < WIN_MIN) begin
      win_cnt = '0;
    end else begin
      win_cnt = CNT_W'(1) << (int'(win) - WIN_MIN + int'(sh));
    end
  end
endmodule

// File: rtl/ifw_meas.sv
module ifw_meas #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             restart,
  input  logic             gate_end,
  input  logic             if_pulse,
  input  logic [CNT_W-1:0] preload,
  input  logic [CNT_W-1:0] win_cnt,
  output logic             result_valid,
  output logic             stop_out
);
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        cnt_nxt;
  logic signed [CNT_W-1:0] resid;
  logic signed [CNT_W-1:0] wmax;
  logic                    in_win;

  assign cnt_nxt = cnt_q - CNT_W'(if_pulse);
  assign resid   = signed'(cnt_nxt);
  assign wmax    = signed'(win_cnt);
  assign in_win  = (resid <= wmax) && (resid >= -wmax);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      result_valid <= 1'b0;
      stop_out     <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (restart) begin
        cnt_q <= preload;
      end else if (gate_end) begin
        cnt_q        <= preload;
        result_valid <= 1'b1;
        stop_out     <= in_win;
      end else begin
        cnt_q <= cnt_nxt;
      end
      if (!active) begin
        stop_out <= 1'b0;
      end
    end
  end

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !gate_end) |=> $stable(stop_out)); // R6
endmodule

// File: rtl/if_window_counter.sv
module if_window_counter #(
  parameter int REF_W    = 14,
  parameter int CNT_W    = 21,
  parameter int FM_BASE  = 1696,
  parameter int AM_BASE  = 448,
  parameter int UPC_BASE = 10688,
  parameter int WIN_MIN  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              if_am_pulse,
  input  logic              if_fm_pulse,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_enable,
  input  logic [REF_W-1:0]  cfg_ref_div,
  input  logic [2:0]        cfg_samp,
  input  logic [2:0]        cfg_win,
  input  logic [4:0]        cfg_ctr,
  output logic              result_valid,
  output logic              stop_out
);
  import ifw_pkg::*;

  logic             active;
  logic             restart;
  logic             base_tick;
  logic             gate_end;
  logic             if_pulse;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] win_cnt;

  assign active   = cfg_enable && (ifw_mode_e'(cfg_mode) != IFM_OFF) &&
                    (int'(cfg_win) >= WIN_MIN);
  assign restart  = cfg_wr || !active;
  assign if_pulse = (ifw_mode_e'(cfg_mode) == IFM_FM) ? if_fm_pulse : if_am_pulse;

  ifw_timebase #(.REF_W(REF_W)) u_tb (
    .clk(clk), .rst(rst), .restart(restart), .osc_tick(osc_tick),
    .ref_div(cfg_ref_div), .base_tick(base_tick)
  );

  ifw_gate #(.SHIFT_W(SAMP_W)) u_gate (
    .clk(clk), .rst(rst), .restart(restart), .base_tick(base_tick),
    .samp(cfg_samp), .gate_end(gate_end)
  );

  ifw_target #(
    .CNT_W(CNT_W), .SHIFT_W(SAMP_W), .WIN_W(WIN_W), .CTR_W(CTR_W),
    .FM_BASE(FM_BASE), .AM_BASE(AM_BASE), .UPC_BASE(UPC_BASE), .WIN_MIN(WIN_MIN)
  ) u_tgt (
    .mode(cfg_mode), .samp(cfg_samp), .win(cfg_win), .ctr(cfg_ctr),
    .preload(preload), .win_cnt(win_cnt)
  );

  ifw_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .active(active), .restart(restart),
    .gate_end(gate_end), .if_pulse(if_pulse), .preload(preload),
    .win_cnt(win_cnt), .result_valid(result_valid), .stop_out(stop_out)
  );

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !active |=> !result_valid); // R7
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !result_valid); // R8
endmodule

// File: tb/if_window_counter_test.sv
`timescale 1ns/1ps
module if_window_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_tick = 1'b1;
  logic        if_am_pulse = 1'b0;
  logic        if_fm_pulse = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_enable = 1'b0;
  logic [13:0] cfg_ref_div = '0;
  logic [2:0]  cfg_samp = '0;
  logic [2:0]  cfg_win = '0;
  logic [4:0]  cfg_ctr = '0;
  logic        result_valid;
  logic        stop_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  if_window_counter uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .if_am_pulse(if_am_pulse),
    .if_fm_pulse(if_fm_pulse), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_enable(cfg_enable), .cfg_ref_div(cfg_ref_div), .cfg_samp(cfg_samp),
    .cfg_win(cfg_win), .cfg_ctr(cfg_ctr), .result_valid(result_valid),
    .stop_out(stop_out)
  );

  typedef struct packed {
    logic        half;
    logic        fm_in;
    logic        pass;
    logic [1:0]  mode;
    logic [2:0]  win;
    logic [2:0]  samp;
    logic [4:0]  ctr;
    logic [13:0] rdiv;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 3'd7, 5'd0,  14'd1999,  16'd1696},  // R4 FM exact centre
    '{1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 3'd7, 5'd0,  14'd1999,  16'd1697},  // R5 upper edge
    '{1'b0, 1'b1, 1'b0, 2'b01, 3'd3, 3'd7, 5'd0,  14'd1999,  16'd1698},  // R5 beyond upper
    '{1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 3'd7, 5'd0,  14'd1999,  16'd1695},  // R5 lower edge
    '{1'b0, 1'b1, 1'b0, 2'b01, 3'd3, 3'd7, 5'd0,  14'd1999,  16'd1694},  // R5 beyond lower
    '{1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 3'd6, 5'd5,  14'd1999,  16'd3404},  // R3 R4 two periods, W=2
    '{1'b0, 1'b1, 1'b0, 2'b01, 3'd3, 3'd6, 5'd5,  14'd1999,  16'd3405},  // R5 scaled window
    '{1'b0, 1'b0, 1'b1, 2'b10, 3'd3, 3'd7, 5'd7,  14'd599,   16'd455},   // R2 R4 AM centre
    '{1'b0, 1'b0, 1'b1, 2'b10, 3'd7, 3'd7, 5'd7,  14'd599,   16'd471},   // R5 widest window edge
    '{1'b0, 1'b0, 1'b0, 2'b10, 3'd7, 3'd7, 5'd7,  14'd599,   16'd472},   // R5 widest window out
    '{1'b0, 1'b0, 1'b1, 2'b11, 3'd4, 3'd7, 5'd31, 14'd10999, 16'd10717}, // R4 upconversion
    '{1'b0, 1'b0, 1'b0, 2'b01, 3'd3, 3'd7, 5'd0,  14'd1999,  16'd1696},  // R2 FM ignores AM input
    '{1'b0, 1'b1, 1'b0, 2'b10, 3'd3, 3'd7, 5'd7,  14'd599,   16'd455},   // R2 AM ignores FM input
    '{1'b1, 1'b1, 1'b1, 2'b01, 3'd3, 3'd7, 5'd0,  14'd999,   16'd1696},  // R1 half-rate osc tick
    '{1'b0, 1'b0, 1'b1, 2'b10, 3'd3, 3'd5, 5'd0,  14'd499,   16'd1788}   // R3 four periods
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat(input vec_t v);
    int l;
    int r;
    l = 1 << (7 - int'(v.samp));
    r = int'(v.rdiv) + 1;
    return v.half ? 2 * l * r - 1 : l * r;
  endfunction

  task automatic apply_cfg(input vec_t v, input logic en);
    @(negedge clk);
    cfg_mode    = v.mode;
    cfg_win     = v.win;
    cfg_samp    = v.samp;
    cfg_ctr     = v.ctr;
    cfg_ref_div = v.rdiv;
    cfg_enable  = en;
    cfg_wr      = 1'b1;
    if_am_pulse = 1'b0;
    if_fm_pulse = 1'b0;
    osc_tick    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_meas(input vec_t v, output int k_seen, output logic res,
                          output logic held, output logic quiet_wr);
    int   lim;
    logic prev;
    lim = lat(v) + 40;
    apply_cfg(v, 1'b1);
    quiet_wr = !result_valid;
    prev     = stop_out;
    held     = 1'b1;
    k_seen   = -1;
    res      = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      osc_tick    = v.half ? k[0] : 1'b1;
      if_fm_pulse = v.fm_in && (k <= int'(v.n));
      if_am_pulse = !v.fm_in && (k <= int'(v.n));
      @(posedge clk);
      @(negedge clk);
      if (result_valid) begin
        k_seen = k;
        res    = stop_out;
        break;
      end
      if (stop_out !== prev) held = 1'b0;
    end
    if_fm_pulse = 1'b0;
    if_am_pulse = 1'b0;
    osc_tick    = 1'b1;
    @(negedge clk);
    chk(result_valid == 1'b0, "R6", "strobe width", int'(result_valid), 0);
  endtask

  task automatic idle_check(input logic [1:0] m, input logic en,
                            input logic [2:0] w, input string what);
    int   k_seen;
    logic res;
    logic held;
    logic qw;
    int   nval;
    vec_t v;
    run_meas(VEC[0], k_seen, res, held, qw);
    chk(res == 1'b1, "R7", {what, " pre-pass"}, int'(res), 1);
    v      = VEC[0];
    v.mode = m;
    v.win  = w;
    apply_cfg(v, en);
    chk(stop_out == 1'b0, "R7", {what, " stop cleared"}, int'(stop_out), 0);
    nval = 0;
    for (int k = 0; k < 2500; k++) begin
      if_fm_pulse = k[0];
      if_am_pulse = k[0];
      @(posedge clk);
      @(negedge clk);
      if (result_valid) nval++;
      if (stop_out) nval++;
    end
    if_fm_pulse = 1'b0;
    if_am_pulse = 1'b0;
    chk(nval == 0, "R7", {what, " no strobe or verdict"}, nval, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int   k_seen;
    logic res;
    logic held;
    logic qw;
    int   nv;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result_valid == 1'b0, "R9", "valid after reset", int'(result_valid), 0);
    chk(stop_out == 1'b0, "R9", "stop after reset", int'(stop_out), 0);

    for (int i = 0; i < NV; i++) begin
      run_meas(VEC[i], k_seen, res, held, qw);
      chk(k_seen == lat(VEC[i]), "R3", $sformatf("gate latency vec %0d", i), k_seen, lat(VEC[i]));
      chk(res == VEC[i].pass, "R5", $sformatf("verdict vec %0d", i), int'(res), int'(VEC[i].pass));
      chk(held == 1'b1, "R6", $sformatf("hold between gates vec %0d", i), int'(held), 1);
      chk(qw == 1'b1, "R8", $sformatf("no strobe after write vec %0d", i), int'(qw), 1);
    end

    // R8: 900 pulses, then a rewrite; the new gate must see only its own pulses
    apply_cfg(VEC[0], 1'b1);
    nv = 0;
    for (int k = 0; k < 900; k++) begin
      if_fm_pulse = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (result_valid) nv++;
    end
    if_fm_pulse = 1'b0;
    chk(nv == 0, "R8", "no strobe in aborted gate", nv, 0);
    run_meas(VEC[0], k_seen, res, held, qw);
    chk(k_seen == 2000, "R8", "restarted gate length", k_seen, 2000);
    chk(res == 1'b1, "R8", "stale pulses discarded", int'(res), 1);

    // R7: each idle cause
    idle_check(2'b00, 1'b1, 3'd3, "mode 00");
    idle_check(2'b01, 1'b0, 3'd3, "enable low");
    idle_check(2'b01, 1'b1, 3'd2, "reserved window");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule